// File: doc/BRIEF.md
# Serially Programmed Five-Output Clock Gate

This block takes one reference clock and produces five gated copies of it. A two-wire serial master controls which copies run. The block is a write-only receiver. It oversamples the serial clock and data lines with a faster system clock, finds the bus framing conditions, and answers only one fixed device address in write direction. Every byte it takes after a matching address is acknowledged.

After the address, each write transfer carries two filler bytes. The block acknowledges them and throws their values away. The next one or two bytes set the enable bits. There is no register pointer, so a later control byte can only be reached by sending every byte before it in the same transfer.

Each output is a non-inverting copy of the reference clock when it is enabled, and stays low when it is disabled. Enable changes cross into the reference clock domain and take effect only while that clock is low. This keeps every output pulse full width.

Top module: `clkbuf_i2c_ctl`

## Requirements
- R1: A falling data edge while the serial clock is high is a START. It restarts the byte sequence at the address byte, including a repeated START in the middle of a transfer.
- R2: A rising data edge while the serial clock is high is a STOP. It ends reception and leaves the data line released (`sda_oe_o` = 0).
- R3: Bytes are 8 bits, sent most significant bit first. For the address byte 0xD2 (7-bit address 1101001 with the direction bit 0) and for every byte after it, the block holds the data line low for the whole high phase of the ninth serial clock.
- R4: If the address byte is any value other than 0xD2, including 0xD3 with the direction bit set, the block does not acknowledge that byte or any later one. It changes no enable until the next START.
- R5: The two bytes right after the address are acknowledged and their values have no effect on any output.
- R6: The first byte after the header is control byte 0. Its bit 0 enables output 0, bit 1 enables output 1, bit 6 enables output 2 and bit 7 enables output 3. A bit value of 1 enables the output and 0 disables it.
- R7: The second byte after the header is control byte 1. Its bit 0 enables output 4. A transfer that ends before this byte leaves output 4 unchanged, and a transfer with only the header changes no output.
- R8: Bytes after control byte 1 are acknowledged and discarded.
- R9: Control byte 0 bits 2 to 5 and control byte 1 bits 1 to 7 have no effect on any output.
- R10: After reset, all five outputs are enabled and follow the reference clock, and the data line is released.
- R11: An enabled output equals the reference clock. A disabled output stays low. Outputs change level only on reference clock edges, so there are no runt pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset for both clock domains |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, pulls the data line low (open-drain acknowledge) |
| ref_clk_i | input | 1 | Reference clock to be distributed |
| clk_o | output | 5 | Gated copies of the reference clock, one per output |

## Verification
The assertions assume that the serial clock runs at least eight times slower than the system clock. Each serial level must therefore last several system cycles, which lets a detected edge and the acknowledge drive that follows it settle inside one low phase. They also assume the master never makes a STOP while the block is holding the data line low. The bench meets both conditions: its bus model holds every quarter bit for six system cycles, and it changes data only in the middle of the low phase. It issues STOP and repeated START only after releasing data in a low phase that follows an acknowledge clock. The reference clock runs without a fixed phase relation to the system clock, and the bench counts any output change that does not line up with a reference edge.

// File: rtl/clkbuf_ctl_pkg.sv
package clkbuf_ctl_pkg;

    localparam int NUM_OUT = 5;
    localparam int BYTE_W  = 8;

    // Merge one received control byte into the enable vector.
    // The bit positions are fixed by the programming model of the block.
    function automatic logic [NUM_OUT-1:0] merge_ctrl(
        input logic [NUM_OUT-1:0] cur,
        input int                 idx,
        input logic [BYTE_W-1:0]  val
    );
        logic [NUM_OUT-1:0] nxt;
        nxt = cur;
        case (idx)
            0: begin
                nxt[0] = val[0];
                nxt[1] = val[1];
                nxt[2] = val[6];
                nxt[3] = val[7];
            end
            1: begin
                nxt[4] = val[0];
            end
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_level_o,
    output logic sda_level_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_state_t;

    smp_state_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sync = {smp_q.scl_sync[SYNC_STAGES-2:0], scl_i};
        smp_d.sda_sync = {smp_q.sda_sync[SYNC_STAGES-2:0], sda_i};
        smp_d.scl_prev = smp_q.scl_sync[TOP];
        smp_d.sda_prev = smp_q.sda_sync[TOP];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            smp_q <= '1;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign scl_level_o = smp_q.scl_sync[TOP];
    assign sda_level_o = smp_q.sda_sync[TOP];
    assign scl_rise_o  = smp_q.scl_sync[TOP] & ~smp_q.scl_prev;
    assign scl_fall_o  = ~smp_q.scl_sync[TOP] & smp_q.scl_prev;
    assign start_o     = smp_q.scl_sync[TOP] & smp_q.scl_prev
                       & smp_q.sda_prev & ~smp_q.sda_sync[TOP];
    assign stop_o      = smp_q.scl_sync[TOP] & smp_q.scl_prev
                       & ~smp_q.sda_prev & smp_q.sda_sync[TOP];

endmodule

// File: rtl/i2c_ctl_receiver.sv
module i2c_ctl_receiver
    import clkbuf_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h69,
    parameter int         HDR_BYTES  = 2,
    parameter int         CTRL_BYTES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scl_level_i,
    input  logic               sda_level_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               start_i,
    input  logic               stop_i,
    output logic               sda_oe_o,
    output logic [NUM_OUT-1:0] en_o
);

    localparam int FIRST_CTRL = 1 + HDR_BYTES;
    localparam int LAST_SLOT  = FIRST_CTRL + CTRL_BYTES;
    localparam int SLOT_W     = $clog2(LAST_SLOT + 1);
    localparam int CNT_W      = $clog2(BYTE_W + 1);

    localparam logic [BYTE_W-1:0]  WRITE_ADDR = {DEV_ADDR, 1'b0};
    localparam logic [SLOT_W-1:0]  SLOT_FIRST = SLOT_W'(FIRST_CTRL);
    localparam logic [SLOT_W-1:0]  SLOT_LAST  = SLOT_W'(LAST_SLOT);
    localparam logic [CNT_W-1:0]   BITS_FULL  = CNT_W'(BYTE_W);

    typedef struct packed {
        logic                active;
        logic                ack_phase;
        logic [CNT_W-1:0]    bitcnt;
        logic [SLOT_W-1:0]   slot;
        logic [BYTE_W-1:0]   shift;
        logic                sda_oe;
        logic [NUM_OUT-1:0]  en;
    } rx_state_t;

    rx_state_t rx_d, rx_q;
    logic      in_ctrl;
    int        ctrl_idx;

    assign in_ctrl  = (rx_q.slot >= SLOT_FIRST) && (rx_q.slot < SLOT_LAST);
    assign ctrl_idx = int'(rx_q.slot) - FIRST_CTRL;

    always_comb begin
        rx_d = rx_q;
        if (start_i) begin
            rx_d.active    = 1'b1;
            rx_d.ack_phase = 1'b0;
            rx_d.bitcnt    = '0;
            rx_d.slot      = '0;
            rx_d.sda_oe    = 1'b0;
        end else if (stop_i) begin
            rx_d.active    = 1'b0;
            rx_d.ack_phase = 1'b0;
            rx_d.bitcnt    = '0;
            rx_d.sda_oe    = 1'b0;
        end else if (rx_q.active) begin
            if (scl_rise_i) begin
                if (!rx_q.ack_phase) begin
                    rx_d.shift  = {rx_q.shift[BYTE_W-2:0], sda_level_i};
                    rx_d.bitcnt = rx_q.bitcnt + 1'b1;
                end else if (in_ctrl) begin
                    // commit at the rising edge of the acknowledge clock
                    rx_d.en = merge_ctrl(rx_q.en, ctrl_idx, rx_q.shift);
                end
            end else if (scl_fall_i) begin
                if (!rx_q.ack_phase && rx_q.bitcnt == BITS_FULL) begin
                    if (rx_q.slot == '0 && rx_q.shift != WRITE_ADDR) begin
                        rx_d.active = 1'b0;
                    end else begin
                        rx_d.ack_phase = 1'b1;
                        rx_d.sda_oe    = 1'b1;
                    end
                end else if (rx_q.ack_phase) begin
                    rx_d.ack_phase = 1'b0;
                    rx_d.sda_oe    = 1'b0;
                    rx_d.bitcnt    = '0;
                    if (rx_q.slot != SLOT_LAST) begin
                        rx_d.slot = rx_q.slot + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_q        <= '0;
            rx_q.en     <= '1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign sda_oe_o = rx_q.sda_oe;
    assign en_o     = rx_q.en;

    // R3: the acknowledge drive begins only while the serial clock is low
    a_r3_ack_begins_scl_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rx_q.sda_oe) |-> !scl_level_i);

    // R3: the drive is kept for as long as the serial clock stays high
    a_r3_ack_held_scl_high : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_q.sda_oe && scl_level_i) |=> rx_q.sda_oe);

    // R2: a STOP always leaves the data line released
    a_r2_stop_releases : assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !rx_q.sda_oe);

    // R4: no drive while not addressed
    a_r4_quiet_when_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_q.active |-> !rx_q.sda_oe);

    // R7: enables only change at a rising serial clock edge
    a_r7_commit_on_rise : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(rx_q.en) |-> $past(scl_rise_i));

endmodule

// File: rtl/clk_gate_lane.sv
module clk_gate_lane #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic clk_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] en_sync;
    } lane_state_t;

    lane_state_t lane_d, lane_q;

    always_comb begin
        lane_d         = lane_q;
        lane_d.en_sync = {lane_q.en_sync[SYNC_STAGES-2:0], en_i};
    end

    // Falling-edge registers: the gate only changes while the clock is low.
    always_ff @(negedge ref_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lane_q <= '1;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign clk_o = ref_clk_i & lane_q.en_sync[SYNC_STAGES-1];

endmodule

// File: rtl/clkbuf_i2c_ctl.sv
module clkbuf_i2c_ctl
    import clkbuf_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         HDR_BYTES   = 2,
    parameter int         CTRL_BYTES  = 2,
    parameter int         LINE_SYNC   = 2,
    parameter int         GATE_SYNC   = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic               ref_clk_i,
    output logic [NUM_OUT-1:0] clk_o
);

    logic               scl_level, sda_level;
    logic               scl_rise, scl_fall;
    logic               start_det, stop_det;
    logic [NUM_OUT-1:0] en_vec;

    i2c_line_sampler #(
        .SYNC_STAGES (LINE_SYNC)
    ) sampler_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .scl_level_o (scl_level),
        .sda_level_o (sda_level),
        .scl_rise_o  (scl_rise),
        .scl_fall_o  (scl_fall),
        .start_o     (start_det),
        .stop_o      (stop_det)
    );

    i2c_ctl_receiver #(
        .DEV_ADDR   (DEV_ADDR),
        .HDR_BYTES  (HDR_BYTES),
        .CTRL_BYTES (CTRL_BYTES)
    ) receiver_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .scl_level_i (scl_level),
        .sda_level_i (sda_level),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .sda_oe_o    (sda_oe_o),
        .en_o        (en_vec)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        clk_gate_lane #(
            .SYNC_STAGES (GATE_SYNC)
        ) lane_i (
            .ref_clk_i (ref_clk_i),
            .rst_ni    (rst_ni),
            .en_i      (en_vec[g]),
            .clk_o     (clk_o[g])
        );
    end

endmodule

// File: tb/clkbuf_i2c_ctl_tb.sv
`timescale 1ns/1ps
module clkbuf_i2c_ctl_tb_top;

    localparam int Q_NS    = 120;  // quarter serial bit = 6 system cycles
    localparam int REF_H   = 15;   // reference half period
    localparam int NV      = 9;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] h0;
        logic [7:0] h1;
        logic [1:0] nd;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] d2;
        logic [4:0] exp;
    } vec_t;

    // expected enables are cumulative, starting from the reset value 11111
    localparam vec_t VECS [NV] = '{
        '{8'hD2, 8'h00, 8'h00, 2'd1, 8'h00, 8'h00, 8'h00, 5'b10000}, // R7 partial
        '{8'hD2, 8'hFF, 8'h55, 2'd2, 8'hC3, 8'h00, 8'h00, 5'b01111}, // R6
        '{8'hD2, 8'h12, 8'h02, 2'd2, 8'h40, 8'h01, 8'h00, 5'b10100}, // R6
        '{8'hD2, 8'h00, 8'hFF, 2'd2, 8'h3C, 8'hFE, 8'h00, 5'b00000}, // R9
        '{8'hD3, 8'h00, 8'h00, 2'd2, 8'hFF, 8'hFF, 8'h00, 5'b00000}, // R4 read
        '{8'hA4, 8'h00, 8'h00, 2'd2, 8'hFF, 8'hFF, 8'h00, 5'b00000}, // R4 addr
        '{8'hD2, 8'hAA, 8'h03, 2'd3, 8'h82, 8'h01, 8'h00, 5'b11010}, // R8
        '{8'hD2, 8'hFF, 8'hFF, 2'd0, 8'h00, 8'h00, 8'h00, 5'b11010}, // R5/R7
        '{8'hD2, 8'h00, 8'h00, 2'd2, 8'h01, 8'h00, 8'h00, 5'b00001}  // R6
    };

    logic       clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [4:0] clk_o;
    wire        sda_line = m_sda & ~sda_oe;

    int checks = 0;
    int failures = 0;
    int glitches = 0;

    always #10 clk = ~clk;
    always #(REF_H) ref_clk = ~ref_clk;

    clkbuf_i2c_ctl dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .ref_clk_i (ref_clk),
        .clk_o     (clk_o)
    );

    // R11: any output change off a reference edge is a runt
    always @(clk_o) begin
        if (rst_n && ($time % REF_H) != 0) glitches++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input logic [4:0] exp, input string req);
        logic [4:0] bad_hi;
        logic [4:0] bad_lo;
        bad_hi = '0;
        bad_lo = '0;
        #400;
        for (int k = 0; k < 3; k++) begin
            @(posedge ref_clk); #3;
            bad_hi |= clk_o ^ exp;
            @(negedge ref_clk); #3;
            bad_lo |= clk_o;
        end
        check((bad_hi | bad_lo) == 0, req, "outputs", {27'd0, bad_hi | bad_lo}, 32'd0);
        check(bad_hi == 0, "R11", "enabled outputs follow ref", {27'd0, bad_hi}, 32'd0);
    endtask

    task automatic scl_bit(input logic b, output logic seen);
        m_sda = b;      #(Q_NS);
        scl   = 1'b1;   #(Q_NS);
        seen  = sda_line; #(Q_NS);
        scl   = 1'b0;   #(Q_NS);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; #(Q_NS);
        scl   = 1'b1; #(Q_NS);
        m_sda = 1'b0; #(Q_NS);
        scl   = 1'b0; #(Q_NS);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #(Q_NS);
        scl   = 1'b1; #(Q_NS);
        m_sda = 1'b1; #(Q_NS);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic seen;
        for (int i = 7; i >= 0; i--) scl_bit(b[i], seen);
        scl_bit(1'b1, seen);
        check((!seen) == exp_ack, req, "acknowledge", {31'd0, !seen}, {31'd0, exp_ack});
    endtask

    task automatic run_vec(input vec_t v);
        bit ack;
        ack = (v.addr == 8'hD2);
        bus_start();
        send_byte(v.addr, ack, ack ? "R3" : "R4");
        send_byte(v.h0, ack, "R5");
        send_byte(v.h1, ack, "R5");
        if (v.nd >= 2'd1) send_byte(v.d0, ack, "R6");
        if (v.nd >= 2'd2) send_byte(v.d1, ack, "R7");
        if (v.nd == 2'd3) send_byte(v.d2, ack, "R8");
        bus_stop();
        check(sda_oe == 1'b0, "R2", "data released after STOP", {31'd0, sda_oe}, 32'd0);
        check_outputs(v.exp, ack ? "R6" : "R4");
    endtask

    initial begin
        #(4_000_000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #95;
        rst_n = 1'b1;
        #200;
        // R10: reset state
        check(sda_oe == 1'b0, "R10", "data released at reset", {31'd0, sda_oe}, 32'd0);
        check_outputs(5'b11111, "R10");

        for (int v = 0; v < NV; v++) run_vec(VECS[v]);

        // R1: repeated START restarts the byte order at the address
        bus_start();
        send_byte(8'hD2, 1'b1, "R1");
        send_byte(8'h00, 1'b1, "R1");
        send_byte(8'h00, 1'b1, "R1");
        send_byte(8'hFF, 1'b1, "R1");
        bus_start();
        send_byte(8'hD2, 1'b1, "R1");
        send_byte(8'hC3, 1'b1, "R1");
        send_byte(8'hC3, 1'b1, "R1");
        send_byte(8'h00, 1'b1, "R1");
        send_byte(8'h01, 1'b1, "R1");
        bus_stop();
        check_outputs(5'b10000, "R1");

        // R10: reset in the middle of operation restores all enables
        @(posedge ref_clk);
        rst_n = 1'b0;
        #(2 * REF_H * 3);
        rst_n = 1'b1;
        check_outputs(5'b11111, "R10");

        check(glitches == 0, "R11", "off-edge output changes", glitches, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule